// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Unit

The block decides, every cycle, which instructions leave the head of a reorder buffer. The buffer presents a window of its oldest W entries for one thread, picked by an external thread selector. Each entry carries its squashed, executed and fault flags, a two-bit class code, its sequence number, the address of the instruction that follows it, and a destination-write flag. All slot decisions are made combinationally in the same cycle. Slot k can act only when every older slot in the window has either retired or drained.

Squashed entries drain without using retire bandwidth. An unexecuted serializing instruction at the head waits until it is the first instruction of the cycle and no stores are awaiting writeback. It then issues a single non-speculative execute request carrying its sequence number. An unexecuted load issues an uncached request. A faulting instruction traps only from the first position with no stores pending. The trap blocks its thread and raises a per-thread trap request a fixed number of cycles later.

Registered state holds each thread's architectural PC and next PC, along with statistics: retired count, drained count, a per-cycle retire histogram and a full-bandwidth cycle count. The free-entry update, done sequence number and per-slot strobes are combinational, so the buffer can pop entries in the same cycle.

Top module: `retire_unit`

## Requirements
- R1: Slots are examined oldest first. An executed, fault-free entry (any class) retires with a `retire_o` pulse. Examination stops at the first invalid entry, and at the first unexecuted entry of class 0 (plain) or 3 (store), which retires nothing.
- R2: A squashed entry drains with a `drain_o` pulse. It does not count toward the retire total, and it adds one to the drained counter.
- R3: An unexecuted entry of class 1 (serializing) stops the window. It raises `nsx_req_o` with `nsx_unc_o` low and its sequence number only when no entry retired before it this cycle and `st_pend_i` is low. After one request, the request stays suppressed for that thread until the thread retires or drains an entry.
- R4: An unexecuted entry of class 2 (load) stops the window and raises `nsx_req_o` with `nsx_unc_o` high and its sequence number, subject to the same once-only suppression as R3.
- R5: An executed entry with its fault flag set stops the window. It traps only when no entry retired before it this cycle and `st_pend_i` is low. A trap blocks all retirement for that thread. The trap also pulses `trap_req_o[t]` for one cycle, starting TRAP_LAT clock edges after the edge that took the trap, and the thread is unblocked in that same cycle.
- R6: On any cycle with at least one retirement, the selected thread's PC becomes the next-PC field of its youngest retired entry, and its next PC becomes that value plus 4. A thread with no retirement keeps both.
- R7: `done_vld_o` is high when anything retires, and `done_seq_o` then carries the youngest retired sequence number. `free_cnt_o` is the number of entries leaving (retired plus drained), and `free_chg_o` is high when that number is non-zero.
- R8: On every cycle with slot 0 valid, histogram bin n (n retired this cycle, 0..W) increments, and the saturation counter increments when n equals W. The retired counter adds n.
- R9: Reset clears all PCs, next PCs, counters, histogram bins and trap state to zero.
- R10: `ren_we_o[k]` is high exactly when slot k retires and its destination-write flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_thr_i | input | TID_W | Thread whose window is presented |
| st_pend_i | input | 1 | Stores awaiting writeback |
| hd_vld_i | input | W | Slot holds an entry |
| hd_sq_i | input | W | Entry is squashed |
| hd_exe_i | input | W | Entry has executed |
| hd_flt_i | input | W | Entry carries a fault |
| hd_dst_i | input | W | Entry writes a destination |
| hd_cls_i | input | 2*W | Class code per slot: 0 plain, 1 serializing, 2 load, 3 store |
| hd_seq_i | input | W*SEQ_W | Sequence number per slot |
| hd_npc_i | input | W*PC_W | Following-instruction address per slot |
| retire_o | output | W | Slot retires this cycle |
| drain_o | output | W | Slot drains this cycle |
| ren_we_o | output | W | Destination retire strobe per slot |
| nsx_req_o | output | 1 | Non-speculative execute request |
| nsx_unc_o | output | 1 | Request is an uncached load |
| nsx_seq_o | output | SEQ_W | Sequence number of the request |
| trap_req_o | output | NT | Delayed trap request per thread |
| done_vld_o | output | 1 | Something retired |
| done_seq_o | output | SEQ_W | Youngest retired sequence number |
| free_chg_o | output | 1 | Entries left the buffer |
| free_cnt_o | output | CW | Number of entries leaving |
| arch_pc_o | output | NT*PC_W | Architectural PC per thread |
| arch_npc_o | output | NT*PC_W | Architectural next PC per thread |
| cnt_ret_o | output | CNT_W | Retired instruction counter |
| cnt_sq_o | output | CNT_W | Drained entry counter |
| hist_o | output | (W+1)*CNT_W | Per-cycle retire histogram, bin n at n*CNT_W |
| sat_cnt_o | output | CNT_W | Cycles with exactly W retirements |

## Verification
On every cycle, the assertions check the following. Retire pulses form an unbroken run behind older retired or drained slots. Execute requests and traps appear only when no stores are pending and nothing retired earlier in the cycle. A blocked thread never takes a second trap, and a thread's PC stays unchanged on cycles where it retires nothing. Only the directed scenarios can show the rest. These are the exact trap delay, the once-only suppression of repeated execute requests, the chosen PC and sequence values, and the histogram bin that moves.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_SERIAL = 2'd1,
    CLS_LOAD   = 2'd2,
    CLS_STORE  = 2'd3
  } cls_e;
endpackage

// File: rtl/retire_slot_chain.sv
module retire_slot_chain
  import retire_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic             en_i,
  input  logic             st_pend_i,
  input  logic [W-1:0]     vld_i,
  input  logic [W-1:0]     sq_i,
  input  logic [W-1:0]     exe_i,
  input  logic [W-1:0]     flt_i,
  input  logic [2*W-1:0]   cls_i,
  input  logic [W*SEQ_W-1:0] seq_i,
  input  logic [W*PC_W-1:0]  npc_i,
  output logic [W-1:0]     retire_o,
  output logic [W-1:0]     drain_o,
  output logic             hold_o,
  output logic             hold_unc_o,
  output logic [SEQ_W-1:0] hold_seq_o,
  output logic             trap_o,
  output logic [CW-1:0]    ncommit_o,
  output logic [SEQ_W-1:0] last_seq_o,
  output logic [PC_W-1:0]  last_npc_o
);
  logic go;
  cls_e cls;

  always_comb begin
    retire_o   = '0;
    drain_o    = '0;
    hold_o     = 1'b0;
    hold_unc_o = 1'b0;
    hold_seq_o = '0;
    trap_o     = 1'b0;
    ncommit_o  = '0;
    last_seq_o = '0;
    last_npc_o = '0;
    go         = en_i;
    cls        = CLS_PLAIN;
    for (int k = 0; k < W; k++) begin
      cls = cls_e'(cls_i[2*k +: 2]);
      if (go && vld_i[k]) begin
        if (sq_i[k]) begin
          drain_o[k] = 1'b1;
        end else if (!exe_i[k]) begin
          go = 1'b0;
          if (cls == CLS_SERIAL && ncommit_o == '0 && !st_pend_i) begin
            hold_o     = 1'b1;
            hold_seq_o = seq_i[k*SEQ_W +: SEQ_W];
          end else if (cls == CLS_LOAD) begin
            hold_o     = 1'b1;
            hold_unc_o = 1'b1;
            hold_seq_o = seq_i[k*SEQ_W +: SEQ_W];
          end
        end else if (flt_i[k]) begin
          go = 1'b0;
          // faults trap only from the first position
          if (ncommit_o == '0 && !st_pend_i) trap_o = 1'b1;
        end else begin
          retire_o[k] = 1'b1;
          ncommit_o   = ncommit_o + CW'(1);
          last_seq_o  = seq_i[k*SEQ_W +: SEQ_W];
          last_npc_o  = npc_i[k*PC_W +: PC_W];
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/retire_trap_timer.sv
module retire_trap_timer #(
  parameter int LAT = 3,
  localparam int TW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pend_o,
  output logic req_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      req_o  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_o <= 1'b0;
      if (start_i) begin
        pend_o <= 1'b1;
        cnt_q  <= TW'(LAT);
      end else if (pend_o) begin
        if (cnt_q > TW'(1)) begin
          cnt_q <= cnt_q - TW'(1);
        end else begin
          pend_o <= 1'b0;
          req_o  <= 1'b1;
        end
      end
    end
  end

  // R5
  no_retrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !pend_o);
  // R5
  req_unblocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !pend_o);
endmodule

// File: rtl/retire_stats.sv
module retire_stats #(
  parameter int W     = 4,
  parameter int CNT_W = 16,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_i,
  input  logic [CW-1:0]          ncommit_i,
  input  logic [CW-1:0]          ndrain_i,
  output logic [CNT_W-1:0]       cnt_ret_o,
  output logic [CNT_W-1:0]       cnt_sq_o,
  output logic [(W+1)*CNT_W-1:0] hist_o,
  output logic [CNT_W-1:0]       sat_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_ret_o <= '0;
      cnt_sq_o  <= '0;
      sat_cnt_o <= '0;
    end else begin
      cnt_ret_o <= cnt_ret_o + CNT_W'(ncommit_i);
      cnt_sq_o  <= cnt_sq_o + CNT_W'(ndrain_i);
      if (sample_i && ncommit_i == CW'(W)) sat_cnt_o <= sat_cnt_o + CNT_W'(1);
    end
  end

  for (genvar b = 0; b <= W; b++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_o[b*CNT_W +: CNT_W] <= '0;
      else if (sample_i && ncommit_i == CW'(b))
        hist_o[b*CNT_W +: CNT_W] <= hist_o[b*CNT_W +: CNT_W] + CNT_W'(1);
    end
  end

  // R8
  sat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && ncommit_i == CW'(W)) |=> $stable(sat_cnt_o));
endmodule

// File: rtl/retire_unit.sv
module retire_unit
  import retire_pkg::*;
#(
  parameter int NT       = 2,
  parameter int W        = 4,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 16,
  parameter int TRAP_LAT = 3,
  parameter int INST_B   = 4,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW      = $clog2(W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TID_W-1:0]       sel_thr_i,
  input  logic                   st_pend_i,
  input  logic [W-1:0]           hd_vld_i,
  input  logic [W-1:0]           hd_sq_i,
  input  logic [W-1:0]           hd_exe_i,
  input  logic [W-1:0]           hd_flt_i,
  input  logic [W-1:0]           hd_dst_i,
  input  logic [2*W-1:0]         hd_cls_i,
  input  logic [W*SEQ_W-1:0]     hd_seq_i,
  input  logic [W*PC_W-1:0]      hd_npc_i,
  output logic [W-1:0]           retire_o,
  output logic [W-1:0]           drain_o,
  output logic [W-1:0]           ren_we_o,
  output logic                   nsx_req_o,
  output logic                   nsx_unc_o,
  output logic [SEQ_W-1:0]       nsx_seq_o,
  output logic [NT-1:0]          trap_req_o,
  output logic                   done_vld_o,
  output logic [SEQ_W-1:0]       done_seq_o,
  output logic                   free_chg_o,
  output logic [CW-1:0]          free_cnt_o,
  output logic [NT*PC_W-1:0]     arch_pc_o,
  output logic [NT*PC_W-1:0]     arch_npc_o,
  output logic [CNT_W-1:0]       cnt_ret_o,
  output logic [CNT_W-1:0]       cnt_sq_o,
  output logic [(W+1)*CNT_W-1:0] hist_o,
  output logic [CNT_W-1:0]       sat_cnt_o
);
  logic [NT-1:0]   trap_pend, trap_start, hold_sent, pc_upd;
  logic            blk, hold, trap;
  logic [CW-1:0]   ncommit, ndrain;
  logic [PC_W-1:0] last_npc;
  logic [PC_W-1:0] pc_q [NT];
  logic [PC_W-1:0] npc_q [NT];

  assign blk = trap_pend[sel_thr_i];

  retire_slot_chain #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W)) chain_i (
    .en_i       (!blk),
    .st_pend_i  (st_pend_i),
    .vld_i      (hd_vld_i),
    .sq_i       (hd_sq_i),
    .exe_i      (hd_exe_i),
    .flt_i      (hd_flt_i),
    .cls_i      (hd_cls_i),
    .seq_i      (hd_seq_i),
    .npc_i      (hd_npc_i),
    .retire_o   (retire_o),
    .drain_o    (drain_o),
    .hold_o     (hold),
    .hold_unc_o (nsx_unc_o),
    .hold_seq_o (nsx_seq_o),
    .trap_o     (trap),
    .ncommit_o  (ncommit),
    .last_seq_o (done_seq_o),
    .last_npc_o (last_npc)
  );

  assign ndrain     = CW'($countones(drain_o));
  assign free_cnt_o = ncommit + ndrain;
  assign free_chg_o = free_cnt_o != '0;
  assign done_vld_o = ncommit != '0;
  assign ren_we_o   = retire_o & hd_dst_i;
  assign nsx_req_o  = hold && !hold_sent[sel_thr_i];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign trap_start[t] = trap && sel_thr_i == TID_W'(t);
    assign pc_upd[t]     = done_vld_o && sel_thr_i == TID_W'(t);

    retire_trap_timer #(.LAT(TRAP_LAT)) timer_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (trap_start[t]),
      .pend_o  (trap_pend[t]),
      .req_o   (trap_req_o[t])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q[t]      <= '0;
        npc_q[t]     <= '0;
        hold_sent[t] <= 1'b0;
      end else if (sel_thr_i == TID_W'(t)) begin
        if (pc_upd[t]) begin
          pc_q[t]  <= last_npc;
          npc_q[t] <= last_npc + PC_W'(INST_B);
        end
        if (free_chg_o || trap) hold_sent[t] <= 1'b0;
        else if (hold)          hold_sent[t] <= 1'b1;
      end
    end

    assign arch_pc_o[t*PC_W +: PC_W]  = pc_q[t];
    assign arch_npc_o[t*PC_W +: PC_W] = npc_q[t];

    // R6
    pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pc_upd[t] |=> $stable(arch_pc_o[t*PC_W +: PC_W]));
  end

  retire_stats #(.W(W), .CNT_W(CNT_W)) stats_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (hd_vld_i[0]),
    .ncommit_i (ncommit),
    .ndrain_i  (ndrain),
    .cnt_ret_o (cnt_ret_o),
    .cnt_sq_o  (cnt_sq_o),
    .hist_o    (hist_o),
    .sat_cnt_o (sat_cnt_o)
  );

  for (genvar k = 1; k < W; k++) begin : g_ord
    // R1
    in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_o[k] |-> (retire_o[k-1] || drain_o[k-1]));
  end

  // R3
  serial_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nsx_req_o && !nsx_unc_o) |-> (!st_pend_i && retire_o == '0));
  // R5
  trap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap |-> (!st_pend_i && retire_o == '0 && !blk));
  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o & drain_o) == '0);
endmodule

// File: tb/retire_unit_tb_top.sv
module retire_unit_tb_top;
  localparam int NT = 2, W = 4, SEQ_W = 16, PC_W = 32, CNT_W = 16, LAT = 3;
  localparam int CW = $clog2(W + 1);

  logic clk = 0, rst_ni = 0;
  always #4 clk = ~clk;

  logic [0:0] sel_thr;
  logic st_pend;
  logic [W-1:0] vld, sq, exe, flt, dst;
  logic [2*W-1:0] cls;
  logic [W*SEQ_W-1:0] seq;
  logic [W*PC_W-1:0] npc;
  logic [W-1:0] retire, drain, ren_we;
  logic nsx_req, nsx_unc, done_vld, free_chg;
  logic [SEQ_W-1:0] nsx_seq, done_seq;
  logic [NT-1:0] trap_req;
  logic [CW-1:0] free_cnt;
  logic [NT*PC_W-1:0] arch_pc, arch_npc;
  logic [CNT_W-1:0] cnt_ret, cnt_sq, sat_cnt;
  logic [(W+1)*CNT_W-1:0] hist;

  int checks = 0, errors = 0;

  retire_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_thr_i(sel_thr), .st_pend_i(st_pend),
    .hd_vld_i(vld), .hd_sq_i(sq), .hd_exe_i(exe), .hd_flt_i(flt), .hd_dst_i(dst),
    .hd_cls_i(cls), .hd_seq_i(seq), .hd_npc_i(npc),
    .retire_o(retire), .drain_o(drain), .ren_we_o(ren_we),
    .nsx_req_o(nsx_req), .nsx_unc_o(nsx_unc), .nsx_seq_o(nsx_seq),
    .trap_req_o(trap_req), .done_vld_o(done_vld), .done_seq_o(done_seq),
    .free_chg_o(free_chg), .free_cnt_o(free_cnt),
    .arch_pc_o(arch_pc), .arch_npc_o(arch_npc),
    .cnt_ret_o(cnt_ret), .cnt_sq_o(cnt_sq), .hist_o(hist), .sat_cnt_o(sat_cnt)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    st_pend = 0; vld = 0; sq = 0; exe = 0; flt = 0; dst = 0; cls = 0; seq = 0; npc = 0;
  endtask

  task automatic slot(int k, bit s, bit e, bit f, logic [1:0] c, int sn, int pc, bit d);
    vld[k] = 1; sq[k] = s; exe[k] = e; flt[k] = f; dst[k] = d;
    cls[2*k +: 2] = c; seq[k*SEQ_W +: SEQ_W] = SEQ_W'(sn); npc[k*PC_W +: PC_W] = PC_W'(pc);
  endtask

  function automatic logic [CNT_W-1:0] bin(int b);
    return hist[b*CNT_W +: CNT_W];
  endfunction

  task automatic t_reset();
    chk("R9 pc", arch_pc, 0);
    chk("R9 npc", arch_npc, 0);
    chk("R9 cnt", {cnt_ret, cnt_sq, sat_cnt}, 0);
    chk("R9 hist", hist, 0);
    chk("R9 trap", trap_req, 0);
  endtask

  task automatic t_full();
    logic [CNT_W-1:0] b4, s0, r0;
    @(negedge clk); clr(); sel_thr = 0;
    b4 = bin(4); s0 = sat_cnt; r0 = cnt_ret;
    for (int k = 0; k < W; k++) slot(k, 0, 1, 0, 2'(k % 2 == 0 ? 0 : 3), 10 + k, 'h104 + 4*k, k[0]);
    #1;
    chk("R1 full", retire, 4'b1111);
    chk("R10 ren", ren_we, 4'b1010);
    chk("R7 done", {31'b0, done_vld, 16'(done_seq)}, {31'b0, 1'b1, 16'd13});
    chk("R7 free", free_cnt, 4);
    @(negedge clk); clr(); #1;
    chk("R6 pc", arch_pc[0 +: PC_W], 'h110);
    chk("R6 npc", arch_npc[0 +: PC_W], 'h114);
    chk("R8 bin4", bin(4), b4 + 1);
    chk("R8 sat", sat_cnt, s0 + 1);
    chk("R8 ret", cnt_ret, r0 + 4);
  endtask

  task automatic t_stop();
    logic [CNT_W-1:0] b1;
    @(negedge clk); clr(); sel_thr = 1; b1 = bin(1);
    slot(0, 0, 1, 0, 0, 20, 'h204, 0);
    slot(1, 0, 0, 0, 3, 21, 'h208, 0);
    slot(2, 0, 1, 0, 0, 22, 'h20c, 0);
    #1;
    chk("R1 stop", retire, 4'b0001);
    chk("R7 seq", done_seq, 20);
    chk("R3 none", nsx_req, 0);
    @(negedge clk); clr(); #1;
    chk("R6 thr1", arch_pc[PC_W +: PC_W], 'h204);
    chk("R6 thr0 kept", arch_pc[0 +: PC_W], 'h110);
    chk("R8 bin1", bin(1), b1 + 1);
  endtask

  task automatic t_drain();
    logic [CNT_W-1:0] q0;
    @(negedge clk); clr(); sel_thr = 0; q0 = cnt_sq;
    slot(0, 1, 0, 0, 0, 30, 0, 1);
    slot(1, 1, 0, 1, 1, 31, 0, 1);
    slot(2, 0, 1, 0, 0, 32, 'h300, 1);
    slot(3, 0, 1, 0, 0, 33, 'h304, 0);
    #1;
    chk("R2 drain", drain, 4'b0011);
    chk("R2 retire", retire, 4'b1100);
    chk("R10 ren", ren_we, 4'b0100);
    chk("R7 free", {free_chg, 3'(free_cnt)}, {1'b1, 3'd4});
    @(negedge clk); clr(); #1;
    chk("R2 sqcnt", cnt_sq, q0 + 2);
  endtask

  task automatic t_serial();
    @(negedge clk); clr(); sel_thr = 0;
    slot(0, 0, 1, 0, 0, 40, 'h400, 0);
    slot(1, 0, 0, 0, 1, 41, 'h404, 0);
    #1;
    chk("R3 not first ret", retire, 4'b0001);
    chk("R3 not first", nsx_req, 0);
    @(negedge clk); clr(); st_pend = 1;
    slot(0, 0, 0, 0, 1, 41, 'h404, 0); #1;
    chk("R3 stores", {nsx_req, retire}, 0);
    @(negedge clk); st_pend = 0; #1;
    chk("R3 req", {nsx_req, nsx_unc}, 2'b10);
    chk("R3 seq", nsx_seq, 41);
    @(negedge clk); #1;
    chk("R3 once", nsx_req, 0);
    @(negedge clk); clr();
  endtask

  task automatic t_load();
    @(negedge clk); clr(); sel_thr = 1; st_pend = 1;
    slot(0, 0, 0, 0, 2, 55, 'h500, 1);
    slot(1, 0, 1, 0, 0, 56, 'h504, 1);
    #1;
    chk("R4 unc", {nsx_req, nsx_unc}, 2'b11);
    chk("R4 seq", nsx_seq, 55);
    chk("R4 stall", retire, 0);
    @(negedge clk); clr();
  endtask

  task automatic t_fault();
    @(negedge clk); clr(); sel_thr = 0;
    slot(0, 0, 1, 0, 0, 60, 'h600, 0);
    slot(1, 0, 1, 1, 0, 61, 'h604, 0);
    #1; chk("R5 not first", retire, 4'b0001);
    @(negedge clk); clr(); st_pend = 1;
    slot(0, 0, 1, 1, 0, 61, 'h604, 0);
    @(negedge clk); #1;
    chk("R5 stores no trap", trap_req, 0);
    chk("R6 pc", arch_pc[0 +: PC_W], 'h600);
    st_pend = 0;
    @(negedge clk); clr();                  // trap taken at previous edge
    slot(0, 0, 1, 0, 0, 62, 'h608, 0); #1;
    chk("R5 blocked", retire, 0);
    @(negedge clk); clr(); #1;
    chk("R5 early", trap_req, 0);
    @(negedge clk); #1;
    chk("R5 early2", trap_req, 0);
    @(negedge clk); slot(0, 0, 1, 0, 0, 62, 'h608, 0); #1;
    chk("R5 req", trap_req, 2'b01);
    chk("R5 unblocked", retire, 4'b0001);
    @(negedge clk); clr(); #1;
    chk("R5 pulse", trap_req, 0);
  endtask

  initial begin
    clr(); sel_thr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_full();
    t_stop();
    t_drain();
    t_serial();
    t_load();
    t_fault();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule